// File: doc/BRIEF.md
# Composite Sync Combiner and Burst Gate

This block takes separate horizontal and vertical sync levels, merges them into one active-low composite sync, and derives two timing flags from it for a video encoder: a burst gate that marks where the colour reference is inserted, and a clamp window that marks where the input black level and the modulator balance are restored. When a finished composite sync is already available, it is fed on the horizontal input with the vertical input held high, and it passes through untouched.

The merged sync is resampled by a clock running at twice the colour subcarrier rate. The width of every low pulse is counted in these clocks. Only a pulse whose width falls in the line-sync band for the selected standard arms the burst gate. Narrow equalizing pulses and wide broad or serration pulses in the vertical interval never produce a burst. Both flags are timed from the falling edge of the resampled sync. The burst therefore starts a fixed number of clocks after that edge. This delay is longer than any valid line-sync pulse, so the classification is complete before the burst begins.

Top module: `csync_burst_gate`

## Requirements
- R1: `csync_raw` is combinational and equals the XNOR of `hsync_in` and `vsync_in`; with `vsync_in` high it equals `hsync_in`, and a low level on either input alone drives it low.
- R2: The merged sync passes through a chain of SYNC_STAGES flops (default 2) clocked by `clk_2sc` before any measurement. Edge 0 is the clock edge that first captures a low level. The sampled sync is low after edges SYNC_STAGES-1 onward.
- R3: A low pulse is a line-sync pulse when its sampled width N (in clocks) satisfies 20 <= N <= 45 with `mode_pal`=0 (NTSC), or 25 <= N <= 56 with `mode_pal`=1 (PAL). Widths of 256 clocks or more saturate the counter and are never line sync.
- R4: The burst gate is raised only for a falling edge whose pulse was classified as line sync. Equalizing, broad and over-long pulses give no burst.
- R5: After a line-sync pulse, `burst_gate` is high after edges D+S through D+S+L-1, counted from edge 0, where S=SYNC_STAGES. D=48 and L=18 (9 subcarrier cycles) for NTSC; D=60 and L=20 for PAL. For both standards D exceeds the largest line-sync width.
- R6: After every falling edge of the sampled sync, whatever its class, `clamp_win` is high after edges 3+S through 3+S+7 (8 clocks). It never overlaps the burst gate.
- R7: A new falling edge of the sampled sync before the burst window cancels the pending burst and restarts both windows from that edge.
- R8: While `rst_n` is low, `burst_gate` and `clamp_win` are low at once, without waiting for a clock edge. Reset release is synchronised internally over two edges of `clk_2sc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2sc | input | 1 | Sampling clock at twice the subcarrier rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active low, or a complete composite sync |
| vsync_in | input | 1 | Vertical sync, active low; tie high when hsync_in carries composite sync |
| mode_pal | input | 1 | Standard select: 0 = NTSC thresholds and timing, 1 = PAL |
| csync_raw | output | 1 | Unsampled merged composite sync |
| burst_gate | output | 1 | Registered colour-burst insertion flag |
| clamp_win | output | 1 | Registered clamp and modulator-balance window |

## Verification
Single low pulses are applied at widths just inside and just outside each edge of both line-sync bands. Widths inside the band must give a burst at the exact cycle offset for the standard, and widths outside must give none, which separates the width limits of the two standards. Pulses arriving on the vertical input show that either source produces the same result. A valid line pulse followed shortly by an equalizing pulse must cancel the burst while still producing two clamp windows. A pulse longer than the counter range shows that saturation never reads as line sync. An asynchronous reset applied during a burst must clear both flags at once.

// File: rtl/csg_pkg.sv
package csg_pkg;

  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } vstd_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/csg_sampler.sv
module csg_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cs_q,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] stg_q, stg_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = din;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], din};
    end
  endgenerate

  always_comb prev_d = stg_q[STAGES-1];

  // idle level of active-low sync is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      prev_q <= 1'b1;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign cs_q = stg_q[STAGES-1];
  assign fall = prev_q & ~cs_q;
  assign rise = ~prev_q & cs_q;

endmodule

// File: rtl/csg_width_cls.sv
module csg_width_cls #(
  parameter int CW       = 8,
  parameter int NT_HMIN  = 20,
  parameter int NT_HMAX  = 45,
  parameter int PAL_HMIN = 25,
  parameter int PAL_HMAX = 56
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_q,
  input  logic fall,
  input  logic rise,
  input  logic mode_pal,
  output logic hvalid
);

  localparam logic [CW-1:0] CNT_SAT = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          hv_q, hv_d;
  logic [CW-1:0] lo_lim, hi_lim;
  logic          in_band;

  always_comb begin
    lo_lim  = mode_pal ? CW'(PAL_HMIN) : CW'(NT_HMIN);
    hi_lim  = mode_pal ? CW'(PAL_HMAX) : CW'(NT_HMAX);
    in_band = (cnt_q >= lo_lim) && (cnt_q <= hi_lim) && (cnt_q != CNT_SAT);
  end

  always_comb begin
    cnt_en = ~cs_q;
    cnt_d  = cnt_q;
    if (cnt_en) begin
      if (fall)                  cnt_d = CW'(1);
      else if (cnt_q != CNT_SAT) cnt_d = cnt_q + CW'(1);
    end
  end

  always_comb begin
    hv_d = hv_q;
    if (fall)      hv_d = 1'b0;
    else if (rise) hv_d = in_band;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hv_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hv_q  <= hv_d;
    end
  end

  assign hvalid = hv_q;

endmodule

// File: rtl/csg_phase_timer.sv
module csg_phase_timer #(
  parameter int PHASE_END = 80,
  parameter int PW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  output logic [PW-1:0] phase
);

  logic [PW-1:0] ph_q, ph_d;
  logic          ph_run;

  always_comb begin
    ph_run = (ph_q != '0);
    ph_d   = ph_q;
    if (fall)                         ph_d = PW'(1);
    else if (ph_run) begin
      if (ph_q == PW'(PHASE_END))     ph_d = '0;
      else                            ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

endmodule

// File: rtl/csg_window.sv
module csg_window #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic [PW-1:0] first,
  input  logic [PW-1:0] len,
  input  logic          qual,
  output logic          win
);

  logic [PW:0] stop_at;
  logic        win_q, win_d;

  always_comb begin
    stop_at = {1'b0, first} + {1'b0, len};
    win_d   = qual && (phase != '0) && (phase >= first) && ({1'b0, phase} < stop_at);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign win = win_q;

endmodule

// File: rtl/csync_burst_gate.sv
module csync_burst_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int CW          = 8,
  parameter int NT_HMIN     = 20,
  parameter int NT_HMAX     = 45,
  parameter int PAL_HMIN    = 25,
  parameter int PAL_HMAX    = 56,
  parameter int NT_BST_DLY  = 48,
  parameter int NT_BST_LEN  = 18,
  parameter int PAL_BST_DLY = 60,
  parameter int PAL_BST_LEN = 20,
  parameter int CLP_DLY     = 3,
  parameter int CLP_LEN     = 8
) (
  input  logic clk_2sc,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic mode_pal,
  output logic csync_raw,
  output logic burst_gate,
  output logic clamp_win
);
  import csg_pkg::*;

  localparam int PHASE_END = max3(NT_BST_DLY + NT_BST_LEN,
                                  PAL_BST_DLY + PAL_BST_LEN,
                                  CLP_DLY + CLP_LEN);
  localparam int PW = $clog2(PHASE_END + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk_2sc or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign csync_raw = ~(hsync_in ^ vsync_in);

  logic          cs_q, fall, rise, hvalid;
  logic [PW-1:0] phase;
  logic [PW-1:0] bst_first, bst_len;
  vstd_e         vstd;

  always_comb begin
    vstd      = mode_pal ? STD_PAL : STD_NTSC;
    bst_first = (vstd == STD_PAL) ? PW'(PAL_BST_DLY) : PW'(NT_BST_DLY);
    bst_len   = (vstd == STD_PAL) ? PW'(PAL_BST_LEN) : PW'(NT_BST_LEN);
  end

  csg_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk_2sc), .rst_n(rst_int_n), .din(csync_raw),
    .cs_q(cs_q), .fall(fall), .rise(rise)
  );

  csg_width_cls #(
    .CW(CW), .NT_HMIN(NT_HMIN), .NT_HMAX(NT_HMAX),
    .PAL_HMIN(PAL_HMIN), .PAL_HMAX(PAL_HMAX)
  ) u_cls (
    .clk(clk_2sc), .rst_n(rst_int_n), .cs_q(cs_q), .fall(fall),
    .rise(rise), .mode_pal(mode_pal), .hvalid(hvalid)
  );

  csg_phase_timer #(.PHASE_END(PHASE_END), .PW(PW)) u_ph (
    .clk(clk_2sc), .rst_n(rst_int_n), .fall(fall), .phase(phase)
  );

  csg_window #(.PW(PW)) u_bst (
    .clk(clk_2sc), .rst_n(rst_int_n), .phase(phase),
    .first(bst_first), .len(bst_len), .qual(hvalid), .win(burst_gate)
  );

  csg_window #(.PW(PW)) u_clp (
    .clk(clk_2sc), .rst_n(rst_int_n), .phase(phase),
    .first(PW'(CLP_DLY)), .len(PW'(CLP_LEN)), .qual(1'b1), .win(clamp_win)
  );

endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int BLEN_MAX = 20,
  parameter int CLEN_MAX = 8
) (
  input logic clk,
  input logic rst_n,
  input logic burst,
  input logic clamp,
  input logic hvalid
);

  logic [7:0] brun_q, crun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brun_q <= '0;
      crun_q <= '0;
    end else begin
      brun_q <= burst ? ((brun_q == 8'hFF) ? brun_q : brun_q + 8'd1) : 8'd0;
      crun_q <= clamp ? ((crun_q == 8'hFF) ? crun_q : crun_q + 8'd1) : 8'd0;
    end
  end

  // R4: burst only while the classifier held a valid line-sync verdict
  assert_burst_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst) |-> $past(hvalid));

  // R5: burst never outlasts the longest configured window
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> (brun_q < 8'(BLEN_MAX)));

  // R6: clamp window length bounded
  assert_clamp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (crun_q < 8'(CLEN_MAX)));

  // R6: clamp and burst never overlap
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> !burst);

endmodule

bind csync_burst_gate csg_checker #(
  .BLEN_MAX((NT_BST_LEN > PAL_BST_LEN) ? NT_BST_LEN : PAL_BST_LEN),
  .CLEN_MAX(CLP_LEN)
) i_csg_checker (
  .clk(clk_2sc), .rst_n(rst_int_n), .burst(burst_gate),
  .clamp(clamp_win), .hvalid(hvalid)
);

// File: tb/test_csync_burst_gate.sv
module test_csync_burst_gate;

  localparam int S     = 2;
  localparam int NT_D  = 48, NT_L = 18;
  localparam int PAL_D = 60, PAL_L = 20;
  localparam int CL_D  = 3,  CL_L = 8;
  localparam int NV    = 14;

  // {pal, src_v, width[8:0], expect_burst}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 9'd10,  1'b0},
    {1'b0, 1'b0, 9'd19,  1'b0},
    {1'b0, 1'b0, 9'd20,  1'b1},
    {1'b0, 1'b0, 9'd33,  1'b1},
    {1'b0, 1'b0, 9'd45,  1'b1},
    {1'b0, 1'b0, 9'd46,  1'b0},
    {1'b0, 1'b0, 9'd120, 1'b0},
    {1'b0, 1'b1, 9'd33,  1'b1},
    {1'b1, 1'b0, 9'd24,  1'b0},
    {1'b1, 1'b0, 9'd25,  1'b1},
    {1'b1, 1'b0, 9'd42,  1'b1},
    {1'b1, 1'b0, 9'd56,  1'b1},
    {1'b1, 1'b0, 9'd57,  1'b0},
    {1'b1, 1'b1, 9'd42,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, hs, vs, pal;
  logic csync_raw, burst_gate, clamp_win;
  int   n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  csync_burst_gate i_csync_burst_gate (
    .clk_2sc(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .mode_pal(pal), .csync_raw(csync_raw), .burst_gate(burst_gate),
    .clamp_win(clamp_win)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // lows: list of (start, width) pulses relative to negedge 0; observes obs cycles
  task automatic run_pulses(input logic src_v, input int st0, input int w0,
                            input int st1, input int w1, input int obs,
                            output int b_cnt, output int b_first,
                            output int c_cnt, output int c_first, output int c_rises);
    logic lvl, c_prev;
    b_cnt = 0; b_first = -1; c_cnt = 0; c_first = -1; c_rises = 0; c_prev = 1'b0;
    for (int j = 0; j <= obs; j++) begin
      if (j > 0) begin
        if (burst_gate) begin b_cnt++; if (b_first < 0) b_first = j; end
        if (clamp_win)  begin c_cnt++; if (c_first < 0) c_first = j; end
        if (clamp_win && !c_prev) c_rises++;
        c_prev = clamp_win;
      end
      lvl = !(((j >= st0) && (j < st0 + w0)) || ((j >= st1) && (j < st1 + w1)));
      if (src_v) begin hs = 1'b1; vs = lvl; end
      else       begin vs = 1'b1; hs = lvl; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int bc, bf, cc, cf, cr, d, l;
    rst_n = 1'b0; hs = 1'b1; vs = 1'b1; pal = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk("R8", int'(burst_gate), 0, "burst in reset");
    chk("R8", int'(clamp_win), 0, "clamp in reset");

    // R1: combinational XNOR truth table
    for (int k = 0; k < 4; k++) begin
      hs = k[0]; vs = k[1]; #1;
      chk("R1", int'(csync_raw), int'(k[0] == k[1]), $sformatf("raw h=%0d v=%0d", k[0], k[1]));
    end
    hs = 1'b1; vs = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4 R5 R6 R2: table walk
    for (int v = 0; v < NV; v++) begin
      int w;
      pal = VEC[v][11];
      w = int'(VEC[v][9:1]);
      d = pal ? PAL_D : NT_D;
      l = pal ? PAL_L : NT_L;
      repeat (3) @(negedge clk);
      run_pulses(VEC[v][10], 0, w, 1000, 0, w + 100, bc, bf, cc, cf, cr);
      chk(VEC[v][0] ? "R5" : "R4", bc, VEC[v][0] ? l : 0, $sformatf("burst length vec %0d w=%0d", v, w));
      if (VEC[v][0])
        chk("R5", bf, d + S + 1, $sformatf("burst start vec %0d", v));
      chk("R6", cc, CL_L, $sformatf("clamp length vec %0d", v));
      chk("R2", cf, CL_D + S + 1, $sformatf("clamp start vec %0d", v));
    end

    // R3: saturation, very long pulse
    pal = 1'b0;
    run_pulses(1'b0, 0, 300, 1000, 0, 400, bc, bf, cc, cf, cr);
    chk("R3", bc, 0, "burst after 300-clock pulse");

    // R7: valid line pulse cancelled by an equalizing pulse
    run_pulses(1'b0, 0, 30, 35, 10, 200, bc, bf, cc, cf, cr);
    chk("R7", bc, 0, "burst after cancel");
    chk("R7", cr, 2, "clamp windows after cancel");
    chk("R7", cc, 2 * CL_L, "clamp cycles after cancel");

    // R8: asynchronous reset during a burst
    hs = 1'b0;
    for (int j = 1; j <= NT_D + S + 5; j++) begin
      @(negedge clk);
      if (j == 30) hs = 1'b1;
    end
    chk("R8", int'(burst_gate), 1, "burst before reset");
    #1 rst_n = 1'b0;
    #1;
    chk("R8", int'(burst_gate), 0, "burst cleared by reset");
    chk("R8", int'(clamp_win), 0, "clamp cleared by reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R8", int'(burst_gate), 0, "no burst after reset release");

    summary();
    $finish;
  end

endmodule